// File: doc/BRIEF.md
# SDI Scrambler and NRZI Bit Serializer

This block turns a stream of 10-bit parallel video words into the single-wire bit sequence of a standard-definition serial digital video link. Each word is captured from the parallel side when its valid strobe is high. The bits are then sent one per serial strobe, least significant bit first. Every bit passes through a self-synchronizing scrambler built on the polynomial X^9 + X^4 + 1, and then through an X + 1 NRZI stage. In that stage a scrambled 1 toggles the line and a scrambled 0 holds it.

The whole block runs on one clock. A bit-enable strobe stands in for the serial clock and is expected to fire ten times per word period. While the lock flag is low, every strobe is ignored and the line stays static. The stream resumes where it stopped once lock returns. The scrambler history is carried across word boundaries, and consecutive words follow each other with no idle bit between them.

Top module: `sdi_serializer`

## Requirements
- R1: While `rst_n` is low, the next clock edge drives `sdo` to 0 and `sdo_n` to 1. The scrambler history, the NRZI level and the word staging are all cleared.
- R2: `sdo_n` is always the complement of `sdo`.
- R3: Each word is transmitted over ten consecutive accepted strobes, bit 0 first and bit 9 last.
- R4: Each transmitted bit is scrambled as s = d XOR s[-4] XOR s[-9], where s[-k] is the scrambled bit sent k accepted strobes earlier (0 before any strobe after reset). A descrambler on the far side therefore recovers every word exactly.
- R5: An NRZI line level changes only on a clock edge where `bit_en` and `lock` are both high, and it toggles exactly when the scrambled bit is 1.
- R6: While `lock` is low, strobes are ignored, `sdo` holds its value and no bit is consumed. Transmission continues without loss when `lock` returns high.
- R7: The first accepted strobe after reset starts word 0. Each later word starts on the accepted strobe right after the tenth bit of the previous one, with no gap.
- R8: `word_in` is captured only on edges where `word_vld` is high. Values presented without the strobe are never transmitted. The word sent at a boundary is the one captured most recently before that boundary.
- R9: After reset, a stream of all-zero words keeps `sdo` at 0, because the cleared scrambler emits only zeros for zero input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for the whole block |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_en | input | 1 | Serial bit strobe, ten per word period |
| lock | input | 1 | High when the serial timing is trustworthy; low freezes the line |
| word_in | input | WORD_W (10) | Parallel word to transmit |
| word_vld | input | 1 | Captures `word_in` into the staging register |
| sdo | output | 1 | NRZI serial line |
| sdo_n | output | 1 | Complement of `sdo` |

## Verification
The bench builds the block with its default word width of 10, a scrambler length of 9 and a tap of 4. This small configuration lets one continuous stream carry every one of the 1024 word values through the far-side descrambler. A second stream uses hashed words with periodic lock drops and missing strobes, which exercises pausing in the middle of a word and at word boundaries. A short all-zero stream pins the NRZI line to a fixed value. Garbage is driven on the word input whenever the valid strobe is low, so any leak of uncaptured data shows up as a mismatch in the recovered words.

// File: rtl/sdi_ser_pkg.sv
package sdi_ser_pkg;
   localparam int unsigned DEF_WORD_W  = 10;
   localparam int unsigned DEF_SCR_LEN = 9;
   localparam int unsigned DEF_SCR_TAP = 4;
endpackage

// File: rtl/sdi_word_shifter.sv
module sdi_word_shifter #(
   parameter int unsigned WORD_W = 10,
   localparam int unsigned CNT_W = $clog2(WORD_W),
   localparam int unsigned LAST  = WORD_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   input  logic [WORD_W-1:0] word_in,
   input  logic              word_vld,
   output logic              bit_o,
   output logic [CNT_W-1:0]  cnt_o,
   output logic [WORD_W-1:0] hold_o
);
   logic [WORD_W-1:0] hold_q, sh_q, src, sh_nx;
   logic [CNT_W-1:0]  cnt_q;
   logic              wrap;

   assign wrap  = (cnt_q == CNT_W'(LAST));
   assign src   = wrap ? hold_q : sh_q;
   assign bit_o = src[0];

   for (genvar i = 0; i < WORD_W; i++) begin : g_shift
      if (i == WORD_W - 1) begin : g_top
         assign sh_nx[i] = 1'b0;
      end else begin : g_mid
         assign sh_nx[i] = src[i+1];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q <= '0;
         sh_q   <= '0;
         cnt_q  <= CNT_W'(LAST);
      end else begin
         if (word_vld) hold_q <= word_in;
         if (adv) begin
            sh_q  <= sh_nx;
            cnt_q <= wrap ? '0 : cnt_q + 1'b1;
         end
      end
   end

   assign cnt_o  = cnt_q;
   assign hold_o = hold_q;
endmodule

// File: rtl/sdi_scrambler.sv
module sdi_scrambler #(
   parameter int unsigned SCR_LEN = 9,
   parameter int unsigned SCR_TAP = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic adv,
   input  logic din,
   output logic dout
);
   logic [SCR_LEN-1:0] hist_q;

   assign dout = din ^ hist_q[SCR_TAP-1] ^ hist_q[SCR_LEN-1];

   always_ff @(posedge clk) begin
      if (!rst_n)   hist_q <= '0;
      else if (adv) hist_q <= {hist_q[SCR_LEN-2:0], dout};
   end
endmodule

// File: rtl/sdi_nrzi.sv
module sdi_nrzi (
   input  logic clk,
   input  logic rst_n,
   input  logic adv,
   input  logic din,
   output logic line_o
);
   logic lvl_q;

   always_ff @(posedge clk) begin
      if (!rst_n)   lvl_q <= 1'b0;
      else if (adv) lvl_q <= lvl_q ^ din;
   end

   assign line_o = lvl_q;
endmodule

// File: rtl/sdi_serializer.sv
module sdi_serializer
   import sdi_ser_pkg::*;
#(
   parameter int unsigned WORD_W  = DEF_WORD_W,
   parameter int unsigned SCR_LEN = DEF_SCR_LEN,
   parameter int unsigned SCR_TAP = DEF_SCR_TAP,
   localparam int unsigned CNT_W  = $clog2(WORD_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic              lock,
   input  logic [WORD_W-1:0] word_in,
   input  logic              word_vld,
   output logic              sdo,
   output logic              sdo_n
);
   if (WORD_W < 2) begin : g_bad_word
      $error("sdi_serializer: WORD_W must be at least 2");
   end
   if (SCR_LEN < 2 || SCR_TAP < 1 || SCR_TAP >= SCR_LEN) begin : g_bad_scr
      $error("sdi_serializer: need 1 <= SCR_TAP < SCR_LEN");
   end

   logic              adv, raw_bit, scr_bit, line;
   logic [CNT_W-1:0]  bit_cnt;
   logic [WORD_W-1:0] hold_q;

   assign adv = bit_en & lock;

   sdi_word_shifter #(.WORD_W(WORD_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .adv(adv),
      .word_in(word_in), .word_vld(word_vld),
      .bit_o(raw_bit), .cnt_o(bit_cnt), .hold_o(hold_q)
   );

   sdi_scrambler #(.SCR_LEN(SCR_LEN), .SCR_TAP(SCR_TAP)) u_scr (
      .clk(clk), .rst_n(rst_n), .adv(adv), .din(raw_bit), .dout(scr_bit)
   );

   sdi_nrzi u_nrzi (
      .clk(clk), .rst_n(rst_n), .adv(adv), .din(scr_bit), .line_o(line)
   );

   assign sdo   = line;
   assign sdo_n = ~line;
endmodule

// File: rtl/sdi_serializer_chk.sv
module sdi_serializer_chk #(
   parameter int unsigned WORD_W = 10,
   localparam int unsigned CNT_W = $clog2(WORD_W),
   localparam int unsigned LAST  = WORD_W - 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bit_en,
   input logic              lock,
   input logic              word_vld,
   input logic              sdo,
   input logic              sdo_n,
   input logic [CNT_W-1:0]  bit_cnt,
   input logic [WORD_W-1:0] hold_q
);
   // R1: reset drives the line idle on the next edge
   a_r1_reset_idle: assert property (@(posedge clk)
      !rst_n |=> (sdo == 1'b0 && sdo_n == 1'b1));

   // R5: no strobe, no line change
   a_r5_no_strobe_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> $stable(sdo));

   // R6: lock low freezes line and bit position
   a_r6_lock_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      !lock |=> ($stable(sdo) && $stable(bit_cnt)));

   // R7: bit position stays within a word and wraps without a gap
   a_r7_count_range: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= CNT_W'(LAST));
   a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && lock && bit_cnt == CNT_W'(LAST)) |=> (bit_cnt == '0));

   // R8: staging register only changes on a valid strobe
   a_r8_hold_keep: assert property (@(posedge clk) disable iff (!rst_n)
      !word_vld |=> $stable(hold_q));
endmodule

bind sdi_serializer sdi_serializer_chk #(.WORD_W(WORD_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .lock(lock),
   .word_vld(word_vld), .sdo(sdo), .sdo_n(sdo_n),
   .bit_cnt(bit_cnt), .hold_q(hold_q)
);

// File: tb/sim_sdi_serializer.sv
module sim_sdi_serializer;
   localparam int CLK_PERIOD = 10;
   localparam int WORD_W     = 10;
   localparam int SCR_LEN    = 9;
   localparam int SCR_TAP    = 4;
   localparam int MASK       = (1 << WORD_W) - 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bit_en = 1'b0;
   logic              lock = 1'b0;
   logic [WORD_W-1:0] word_in = '0;
   logic              word_vld = 1'b0;
   logic              sdo, sdo_n;

   int errors = 0;
   int checks = 0;

   sdi_serializer #(.WORD_W(WORD_W), .SCR_LEN(SCR_LEN), .SCR_TAP(SCR_TAP)) u0 (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .lock(lock),
      .word_in(word_in), .word_vld(word_vld), .sdo(sdo), .sdo_n(sdo_n)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // far-side receiver state
   logic              prev_lvl;
   logic [SCR_LEN-1:0] dsc;
   logic [WORD_W-1:0] acc;
   int                nb;
   int                kword;

   function automatic logic [WORD_W-1:0] wgen(input int mode, input int k);
      if (mode == 0)      return WORD_W'(k & MASK);
      else if (mode == 1) return WORD_W'((k * 613 + 5) & MASK);
      else                return '0;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; bit_en = 1'b1; lock = 1'b1; word_vld = 1'b0;
      @(posedge clk); @(negedge clk);
      check(sdo == 1'b0 && sdo_n == 1'b1, "R1 reset line idle", {sdo, sdo_n}, 2'b01);
      @(posedge clk); @(negedge clk);
      rst_n = 1'b1; bit_en = 1'b0;
      prev_lvl = 1'b0; dsc = '0; acc = '0; nb = 0; kword = 0;
   endtask

   // decode one accepted bit from the line
   task automatic rx_bit(input int mode);
      logic s, b;
      s = sdo ^ prev_lvl;
      prev_lvl = sdo;
      b = s ^ dsc[SCR_TAP-1] ^ dsc[SCR_LEN-1];
      dsc = {dsc[SCR_LEN-2:0], s};
      acc[nb] = b;
      nb++;
      if (mode == 2)
         check(sdo == 1'b0, "R9 zero stream keeps line low", sdo, 0);
      if (nb == WORD_W) begin
         // R3/R4 LSB-first order and scrambling recovered by descrambler; R7 no gap
         check(acc == wgen(mode, kword), "R3/R4/R7/R8 recovered word",
               acc, wgen(mode, kword));
         nb = 0; kword++;
      end
   endtask

   task automatic run_stream(input int mode, input int nwords);
      int t = 0;
      int cyc = 0;
      bit go;
      logic snap;
      do_reset();
      // stage word 0 before the first strobe
      word_in = wgen(mode, 0); word_vld = 1'b1; bit_en = 1'b0;
      @(posedge clk); @(negedge clk);
      while (t < nwords * WORD_W) begin
         bit drop_lock, drop_en;
         drop_lock = (mode == 1) && (cyc % 23 == 7);
         drop_en   = (mode == 1) && (cyc % 17 == 3);
         lock   = !drop_lock;
         bit_en = !drop_en;
         go     = !drop_lock && !drop_en;
         if (t % WORD_W == 4) begin
            word_vld = 1'b1; word_in = wgen(mode, t / WORD_W + 1);
         end else begin
            word_vld = 1'b0; word_in = WORD_W'((cyc * 91 + 17) & MASK);
         end
         snap = sdo;
         @(posedge clk); @(negedge clk);
         check(sdo_n == ~sdo, "R2 complement", sdo_n, ~sdo);
         if (go) begin
            rx_bit(mode);
            t++;
         end else if (drop_lock) begin
            check(sdo == snap, "R6 line static without lock", sdo, snap);
         end else begin
            check(sdo == snap, "R5 line static without strobe", sdo, snap);
         end
         cyc++;
      end
      bit_en = 1'b0; word_vld = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      run_stream(2, 8);     // R9 zero stream
      run_stream(0, 1024);  // every word value back to back
      run_stream(1, 300);   // hashed words with lock drops and missing strobes
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule